// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Break Generation

This block serialises bytes for an asynchronous serial line. Software writes a byte through a data strobe into a one-entry holding register. When the shifter is free, the byte moves into a shift register and goes out as a frame: a low start bit, the data bits least significant first, an optional ninth bit, and a high stop bit. Bit timing comes from an external one-cycle baud tick. Each bit holds until the next tick, and the first bit begins in the cycle the frame is launched.

A control byte, written through its own strobe and always readable, does several jobs. It enables the transmitter, selects 9-bit frames, and supplies the ninth data bit. It can request a break, which is a start bit followed by twelve low bit periods and a stop bit. The request bit clears itself when the break completes. A read-only bit of the control byte shows whether the shifter is empty. An interrupt output is high while the holding register can take a byte. A static input inverts the polarity of the serial pin.

The sequencer has six states. IDLE has two exits: launch-break to START when a break is requested, and otherwise launch-data to START when the holding register is full. START goes to BREAK for a break frame or to DATA for a data frame on a tick. DATA moves to NINTH in 9-bit mode, or to STOP otherwise, on the tick that ends its last bit. NINTH goes to STOP on a tick. BREAK goes to STOP on the tick that ends its twelfth low period. STOP returns to IDLE on a tick. Clearing the enable takes every state straight back to IDLE.

Top module: `uart_txb`

## Requirements
- R1: After reset the serial pin is high (with polarity not inverted), the interrupt is high, and the control readback is 0x02.
- R2: A data frame in 8-bit mode is one low start bit, eight data bits least significant first, then one high stop bit, with each bit lasting one baud tick.
- R3: When control bit 6 is set at launch, a ninth bit equal to control bit 0 (as it was at launch) is sent between the last data bit and the stop bit.
- R4: While enabled, a data write drops the interrupt in the next cycle. The interrupt rises in the cycle the byte moves into the shifter. A byte written during a frame is sent right after that frame's stop bit.
- R5: Setting control bit 3 while the shifter is idle sends a break frame: one low start bit, twelve more low bit periods, then a high stop bit. Bit 3 then reads 0.
- R6: When a break request and a full holding register are both pending in IDLE, the break goes first. The byte stays held (interrupt low) and follows the break.
- R7: With the polarity input high, the serial pin is the inverse of the line level: low when idle, high for the start bit.
- R8: Clearing control bit 5 returns the pin to the idle level and sets the empty flag within two cycles, and it discards any held byte (interrupt high). Data writes while disabled are ignored, so nothing is sent after the block is enabled again.
- R9: Control readback bit 1 is 0 while a frame is being shifted and 1 otherwise. Writes to bit 1 have no effect.
- R10: Control bits 0, 2, 4, 5, 6 and 7 read back as last written. Bits 2, 4 and 7 are storage only and do not change the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle pulse marking each bit boundary |
| ctl_wr | input | 1 | Control write strobe |
| ctl_wdata | input | 8 | Control write value |
| data_wr | input | 1 | Holding register write strobe |
| data_wdata | input | 8 | Byte to transmit |
| invert_pol | input | 1 | Inverts the serial pin when high |
| ctl_rdata | output | 8 | Control readback, bit 1 = shifter empty |
| txd | output | 1 | Serial output pin |
| tx_irq | output | 1 | High while the holding register is empty |

## Verification
The case hardest to reach from the ports is a break request and a held byte that are both pending when the sequencer is in IDLE. A byte written alone launches in the very next cycle, so it never waits beside a request. The stimulus therefore pulses both strobes in the same cycle, with the enable already set. The scoreboard then expects the break frame first and the byte second, and the interrupt is checked low in the middle of the break. Aborting a frame by disabling mid-shift is also driven while a second byte is held, and then no frame may appear after the block is enabled again.

// File: rtl/uart_txb_pkg.sv
package uart_txb_pkg;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_NINTH,
        TX_BREAK,
        TX_STOP
    } tx_state_e;

    localparam int CTL_W        = 8;
    localparam int CTL_NINTH    = 0;
    localparam int CTL_EMPTY    = 1;
    localparam int CTL_BRK      = 3;
    localparam int CTL_EN       = 5;
    localparam int CTL_NINE     = 6;

endpackage

// File: rtl/txb_ctl_reg.sv
module txb_ctl_reg
    import uart_txb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [CTL_W-1:0] wdata,
    input  logic             brk_done,
    input  logic             shift_empty,
    output logic [CTL_W-1:0] rdata,
    output logic             en,
    output logic             nine,
    output logic             ninth_bit,
    output logic             brk_req
);

    logic [CTL_W-1:0] ctl_q;
    logic [CTL_W-1:0] ctl_d;

    always_comb begin
        ctl_d = ctl_q;
        if (wr) begin
            ctl_d = wdata;
        end else if (brk_done) begin
            ctl_d[CTL_BRK] = 1'b0;
        end
        ctl_d[CTL_EMPTY] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_comb begin
        rdata            = ctl_q;
        rdata[CTL_EMPTY] = shift_empty;
    end

    assign en        = ctl_q[CTL_EN];
    assign nine      = ctl_q[CTL_NINE];
    assign ninth_bit = ctl_q[CTL_NINTH];
    assign brk_req   = ctl_q[CTL_BRK];

endmodule

// File: rtl/txb_hold.sv
module txb_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              take,
    output logic [DATA_W-1:0] data,
    output logic              full
);

    logic              full_q;
    logic              full_d;
    logic [DATA_W-1:0] data_q;

    always_comb begin
        if (!en) begin
            full_d = 1'b0;
        end else if (wr) begin
            full_d = 1'b1;
        end else if (take) begin
            full_d = 1'b0;
        end else begin
            full_d = full_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full_q <= 1'b0;
            data_q <= '0;
        end else begin
            full_q <= full_d;
            if (en && wr) begin
                data_q <= wdata;
            end
        end
    end

    assign data = data_q;
    assign full = full_q;

endmodule

// File: rtl/txb_shifter.sv
module txb_shifter
    import uart_txb_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int BRK_LEN = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              tick,
    input  logic              hold_full,
    input  logic [DATA_W-1:0] hold_data,
    input  logic              nine,
    input  logic              ninth_bit,
    input  logic              brk_req,
    output logic              take,
    output logic              brk_done,
    output logic              idle,
    output logic              line
);

    localparam int CNT_MAX = (DATA_W > BRK_LEN) ? DATA_W : BRK_LEN;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam int SH_W    = DATA_W + 1;

    tx_state_e         state_q, state_d;
    logic [SH_W-1:0]   shreg_q, shreg_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic              brk_q, brk_d;
    logic              nine_q, nine_d;
    logic              line_q, line_d;

    // next-state process
    always_comb begin
        state_d  = state_q;
        shreg_d  = shreg_q;
        cnt_d    = cnt_q;
        brk_d    = brk_q;
        nine_d   = nine_q;
        take     = 1'b0;
        brk_done = 1'b0;
        if (!en) begin
            state_d = TX_IDLE;
            shreg_d = '0;
            cnt_d   = '0;
            brk_d   = 1'b0;
        end else begin
            unique case (state_q)
                TX_IDLE: begin
                    if (brk_req) begin
                        state_d = TX_START;
                        brk_d   = 1'b1;
                        cnt_d   = '0;
                    end else if (hold_full) begin
                        take    = 1'b1;
                        state_d = TX_START;
                        brk_d   = 1'b0;
                        nine_d  = nine;
                        shreg_d = {nine & ninth_bit, hold_data};
                        cnt_d   = '0;
                    end
                end
                TX_START: begin
                    if (tick) begin
                        cnt_d   = '0;
                        state_d = brk_q ? TX_BREAK : TX_DATA;
                    end
                end
                TX_DATA: begin
                    if (tick) begin
                        shreg_d = shreg_q >> 1;
                        if (cnt_q == CNT_W'(DATA_W - 1)) begin
                            cnt_d   = '0;
                            state_d = nine_q ? TX_NINTH : TX_STOP;
                        end else begin
                            cnt_d = cnt_q + 1'b1;
                        end
                    end
                end
                TX_NINTH: begin
                    if (tick) begin
                        state_d = TX_STOP;
                    end
                end
                TX_BREAK: begin
                    if (tick) begin
                        if (cnt_q == CNT_W'(BRK_LEN - 1)) begin
                            cnt_d   = '0;
                            state_d = TX_STOP;
                        end else begin
                            cnt_d = cnt_q + 1'b1;
                        end
                    end
                end
                TX_STOP: begin
                    if (tick) begin
                        state_d  = TX_IDLE;
                        brk_done = brk_q;
                        brk_d    = 1'b0;
                    end
                end
                default: begin
                    state_d = TX_IDLE;
                end
            endcase
        end
    end

    // output process: line level follows the state being entered
    always_comb begin
        unique case (state_d)
            TX_IDLE:  line_d = 1'b1;
            TX_START: line_d = 1'b0;
            TX_DATA:  line_d = shreg_d[0];
            TX_NINTH: line_d = shreg_d[0];
            TX_BREAK: line_d = 1'b0;
            TX_STOP:  line_d = 1'b1;
            default:  line_d = 1'b1;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
            shreg_q <= '0;
            cnt_q   <= '0;
            brk_q   <= 1'b0;
            nine_q  <= 1'b0;
            line_q  <= 1'b1;
        end else begin
            state_q <= state_d;
            shreg_q <= shreg_d;
            cnt_q   <= cnt_d;
            brk_q   <= brk_d;
            nine_q  <= nine_d;
            line_q  <= line_d;
        end
    end

    assign idle = (state_q == TX_IDLE);
    assign line = line_q;

endmodule

// File: rtl/uart_txb.sv
module uart_txb
    import uart_txb_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int BRK_LEN = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             baud_tick,
    input  logic             ctl_wr,
    input  logic [7:0]       ctl_wdata,
    input  logic             data_wr,
    input  logic [DATA_W-1:0] data_wdata,
    input  logic             invert_pol,
    output logic [7:0]       ctl_rdata,
    output logic             txd,
    output logic             tx_irq
);

    logic              en, nine, ninth_bit, brk_req;
    logic              take, brk_done, idle, line;
    logic              hold_full;
    logic [DATA_W-1:0] hold_data;

    txb_ctl_reg u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr          (ctl_wr),
        .wdata       (ctl_wdata),
        .brk_done    (brk_done),
        .shift_empty (idle),
        .rdata       (ctl_rdata),
        .en          (en),
        .nine        (nine),
        .ninth_bit   (ninth_bit),
        .brk_req     (brk_req)
    );

    txb_hold #(.DATA_W(DATA_W)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .wr    (data_wr),
        .wdata (data_wdata),
        .take  (take),
        .data  (hold_data),
        .full  (hold_full)
    );

    txb_shifter #(.DATA_W(DATA_W), .BRK_LEN(BRK_LEN)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .tick      (baud_tick),
        .hold_full (hold_full),
        .hold_data (hold_data),
        .nine      (nine),
        .ninth_bit (ninth_bit),
        .brk_req   (brk_req),
        .take      (take),
        .brk_done  (brk_done),
        .idle      (idle),
        .line      (line)
    );

    assign txd    = line ^ invert_pol;
    assign tx_irq = ~hold_full;

endmodule

// File: rtl/txb_checker.sv
module txb_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       ctl_wr,
    input logic       data_wr,
    input logic       invert_pol,
    input logic [7:0] ctl_rdata,
    input logic       txd,
    input logic       tx_irq
);

    AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rdata[1] |-> ((txd ^ invert_pol) == 1'b1)); // R9

    AST_START_BIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctl_rdata[1]) |-> ((txd ^ invert_pol) == 1'b0)); // R2

    AST_IRQ_FALL_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_irq) |-> $past(data_wr)); // R4

    AST_DISABLE_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_rdata[5] |=> (ctl_rdata[1] && tx_irq)); // R8

    AST_BRK_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctl_rdata[3]) |-> (ctl_rdata[1] || $past(ctl_wr))); // R5

endmodule

bind uart_txb txb_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_wr     (ctl_wr),
    .data_wr    (data_wr),
    .invert_pol (invert_pol),
    .ctl_rdata  (ctl_rdata),
    .txd        (txd),
    .tx_irq     (tx_irq)
);

// File: tb/sim_uart_txb.sv
`timescale 1ns/1ps
module sim_uart_txb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       ctl_wr = 1'b0;
    logic [7:0] ctl_wdata = '0;
    logic       data_wr = 1'b0;
    logic [7:0] data_wdata = '0;
    logic       invert_pol = 1'b0;
    logic [7:0] ctl_rdata;
    logic       txd;
    logic       tx_irq;

    int n_vec  = 0;
    int n_fail = 0;
    logic mon_off = 1'b0;

    logic [15:0] exp_bits[$];
    int          exp_len[$];

    always #2 clk = ~clk;

    uart_txb u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .baud_tick  (baud_tick),
        .ctl_wr     (ctl_wr),
        .ctl_wdata  (ctl_wdata),
        .data_wr    (data_wr),
        .data_wdata (data_wdata),
        .invert_pol (invert_pol),
        .ctl_rdata  (ctl_rdata),
        .txd        (txd),
        .tx_irq     (tx_irq)
    );

    // baud tick every 5 cycles
    initial begin
        forever begin
            repeat (4) begin
                @(posedge clk);
                #1 baud_tick = 1'b0;
            end
            @(posedge clk);
            #1 baud_tick = 1'b1;
        end
    end

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic ctl_write(input logic [7:0] v);
        @(posedge clk);
        #1 ctl_wr = 1'b1; ctl_wdata = v;
        @(posedge clk);
        #1 ctl_wr = 1'b0;
    endtask

    task automatic data_write(input logic [7:0] b);
        @(posedge clk);
        #1 data_wr = 1'b1; data_wdata = b;
        @(posedge clk);
        #1 data_wr = 1'b0;
    endtask

    task automatic both_write(input logic [7:0] v, input logic [7:0] b);
        @(posedge clk);
        #1 ctl_wr = 1'b1; ctl_wdata = v; data_wr = 1'b1; data_wdata = b;
        @(posedge clk);
        #1 ctl_wr = 1'b0; data_wr = 1'b0;
    endtask

    // driver side of the scoreboard: expected frame, one sample per tick
    task automatic push_data(input logic [7:0] b, input logic nine, input logic ninth);
        logic [15:0] f;
        f = '0;
        f[0] = 1'b0;
        f[8:1] = b;
        if (nine) begin
            f[9]  = ninth;
            f[10] = 1'b1;
            exp_len.push_back(11);
        end else begin
            f[9] = 1'b1;
            exp_len.push_back(10);
        end
        exp_bits.push_back(f);
    endtask

    task automatic push_break();
        logic [15:0] f;
        f = '0;
        f[13] = 1'b1;
        exp_bits.push_back(f);
        exp_len.push_back(14);
    endtask

    task automatic wait_idle();
        forever begin
            @(negedge clk);
            if (exp_len.size() == 0 && ctl_rdata[1] && tx_irq) break;
        end
    endtask

    // monitor side: collect per-tick line samples, compare each frame
    logic [15:0] col = '0;
    int          ncol = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (mon_off) begin
                ncol = 0;
                col  = '0;
            end else begin
                if (!ctl_rdata[1] && baud_tick && ncol < 16) begin
                    col[ncol] = txd ^ invert_pol;
                    ncol++;
                end
                if (ctl_rdata[1] && ncol > 0) begin
                    if (exp_len.size() == 0) begin
                        n_vec++;
                        n_fail++;
                        $display("FAIL R2: actual frame %h len %0d expected no frame", col, ncol);
                    end else begin
                        logic [15:0] e;
                        int el;
                        e  = exp_bits.pop_front();
                        el = exp_len.pop_front();
                        check("R2/R3/R5 frame length", 16'(ncol), 16'(el));
                        check("R2/R3/R5 frame bits", col, e);
                    end
                    ncol = 0;
                    col  = '0;
                end
            end
        end
    end

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_vec++;
        n_fail++;
        $display("FAIL R2: watchdog expired, actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 txd", 16'(txd), 16'h1);
        check("R1 irq", 16'(tx_irq), 16'h1);
        check("R1 ctl readback", 16'(ctl_rdata), 16'h02);

        ctl_write(8'h20);
        @(negedge clk);
        check("R10 enable readback", 16'(ctl_rdata), 16'h22);

        // R2 single 8-bit frame, R4 irq drop
        push_data(8'hA5, 1'b0, 1'b0);
        data_write(8'hA5);
        @(negedge clk);
        check("R4 irq low after write", 16'(tx_irq), 16'h0);
        @(negedge clk);
        check("R4 irq high at launch", 16'(tx_irq), 16'h1);
        wait_idle();

        // R4 back-to-back
        push_data(8'h3C, 1'b0, 1'b0);
        data_write(8'h3C);
        while (!tx_irq) @(negedge clk);
        push_data(8'hC3, 1'b0, 1'b0);
        data_write(8'hC3);
        @(negedge clk);
        check("R4 irq low while second byte held", 16'(tx_irq), 16'h0);
        check("R9 busy during frame", 16'(ctl_rdata[1]), 16'h0);
        wait_idle();

        // R3 nine-bit frames
        ctl_write(8'h61);
        push_data(8'h5A, 1'b1, 1'b1);
        data_write(8'h5A);
        wait_idle();
        ctl_write(8'h60);
        push_data(8'hFF, 1'b1, 1'b0);
        data_write(8'hFF);
        wait_idle();

        // R5 break
        ctl_write(8'h20);
        push_break();
        ctl_write(8'h28);
        wait_idle();
        check("R5 break bit cleared", 16'(ctl_rdata), 16'h22);

        // R6 break ahead of held byte
        push_break();
        push_data(8'h81, 1'b0, 1'b0);
        both_write(8'h28, 8'h81);
        repeat (20) @(negedge clk);
        check("R6 byte held during break", 16'(tx_irq), 16'h0);
        wait_idle();

        // R7 inverted pin
        invert_pol = 1'b1;
        @(negedge clk);
        check("R7 idle inverted", 16'(txd), 16'h0);
        push_data(8'h0F, 1'b0, 1'b0);
        data_write(8'h0F);
        @(negedge clk);
        @(negedge clk);
        check("R7 start bit inverted", 16'(txd), 16'h1);
        wait_idle();
        invert_pol = 1'b0;

        // R8 disable mid-frame with a byte held
        mon_off = 1'b1;
        data_write(8'h55);
        while (!tx_irq) @(negedge clk);
        data_write(8'h66);
        repeat (12) @(negedge clk);
        ctl_write(8'h00);
        repeat (2) @(negedge clk);
        check("R8 txd idle", 16'(txd), 16'h1);
        check("R8 empty flag", 16'(ctl_rdata), 16'h02);
        check("R8 irq high", 16'(tx_irq), 16'h1);
        data_write(8'h77);
        repeat (2) @(negedge clk);
        check("R8 write ignored when disabled", 16'(tx_irq), 16'h1);
        ctl_write(8'h20);
        repeat (30) @(negedge clk);
        check("R8 nothing sent after enable", 16'(ctl_rdata[1]), 16'h1);
        check("R8 no held byte after enable", 16'(tx_irq), 16'h1);
        mon_off = 1'b0;
        @(negedge clk);

        push_data(8'h99, 1'b0, 1'b0);
        data_write(8'h99);
        wait_idle();

        // R10 readback of stored bits, R9 bit1 not writable
        ctl_write(8'hB5);
        @(negedge clk);
        check("R10 stored bits", 16'(ctl_rdata), 16'hB7);
        push_data(8'h42, 1'b0, 1'b0);
        data_write(8'h42);
        wait_idle();
        ctl_write(8'h20);
        @(negedge clk);
        check("R9 bit1 write ignored", 16'(ctl_rdata), 16'h22);

        check("R4 all frames seen", 16'(exp_len.size()), 16'h0);
        finish_run();
    end

endmodule